// File: doc/BRIEF.md
# Bit-Serial SIMD Cell Array

A square grid of one-bit processing elements driven by a single 13-bit instruction word that is broadcast to every element each clock. Each element has a private single-bit RAM, four one-bit registers (a north/south operand, an east/west operand, a carry/borrow flag and a shift-chain bit) and a one-bit full adder/subtractor. The instruction is split into five source-select fields. Up to five register and RAM transfers therefore happen in parallel in one cycle. Multi-bit arithmetic is built by a sequencer outside this block, which steps through the operand bits one RAM address at a time.

The shift-chain registers form a second vertical path that does not pass through the ALU. A row of external data enters at the south edge and moves one row north per shift cycle, and the top row is visible at the north edge. This shift can overlap any ALU work. A mode input selects how the edges connect. In torus mode every row and every column wraps around. In chain mode the rows are joined end to end into one serpentine line, and the vertical edges read zero.

Top module: `simd_pe_array`

## Requirements
- R1: A clock edge with `rst_n` low clears the NS, EW, C and CM registers of every element, so `north_out` reads 0 after reset. The RAM is not cleared.
- R2: Instruction bits [12:10] select the RAM write source, [9:7] the NS source, [6:4] the EW source, [3:2] the C source and [1:0] the CM source. Every element applies the same word in the same cycle. Code 0 in any register field keeps that register unchanged. The RAM bit at `ram_addr` is written only when `ram_we` is 1. Write source codes: 0 SM, 1 CY, 2 BW, 3 NS, 4 EW, 5 C, 6 CM, 7 constant zero.
- R3: The ALU takes NS as operand A, EW as operand B and C as the carry or borrow in. It gives SM = A xor B xor C, CY = majority(A, B, C), and BW = the borrow out of A minus B minus C.
- R4: NS source codes: 1 RAM, 2 NS of the north neighbour, 3 NS of the south neighbour, 4 SM, 5 CY, 6 BW, 7 own EW. Element (r,c) has flat index r*COLS+c, and row 0 is the north edge. In torus mode the north neighbour of row 0 is row ROWS-1 in the same column, and the south neighbour of row ROWS-1 is row 0. In chain mode those edge reads give 0.
- R5: EW source codes: 1 RAM, 2 EW of the east neighbour, 3 EW of the west neighbour, 4 SM, 5 CY, 6 BW, 7 own NS. In torus mode each row wraps onto itself. In chain mode the east neighbour of flat index i is i+1 and the west neighbour is i-1, crossing row ends. The west read of index 0 and the east read of the last index give 0.
- R6: CM source codes: 1 shift, 2 RAM, 3 SM. On a shift, each element takes the CM of its south neighbour, and the bottom row takes `south_in[c]`. `north_out[c]` is the CM of row 0, column c. The shift works the same whatever the other fields do.
- R7: C source codes: 1 RAM, 2 CY, 3 BW.
- R8: Clearing C and then, for each bit, loading NS and EW from RAM and writing SM while C takes CY gives the exact multi-bit sum with its carry out. The same steps with C taking BW give the difference with its borrow out. This holds across the full operand range.
- R9: The RAM read is combinational at `ram_addr`. A write takes effect at the clock edge, so a load from the same address in the same cycle sees the old bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| instr | input | 13 | Broadcast instruction word |
| ram_addr | input | 5 | Shared RAM bit address |
| ram_we | input | 1 | Shared RAM write enable |
| torus_mode | input | 1 | 1 = wrapped 2D torus, 0 = serpentine 1D chain |
| south_in | input | COLS (4) | Data row entering the bottom row on a shift |
| north_out | output | COLS (4) | CM bits of the top row |

## Verification
The assertions assume that `instr`, `ram_addr`, `ram_we`, `torus_mode` and `south_in` are stable around the rising edge and hold no unknown bits. They also assume that `torus_mode` changes only between instructions, which the edge-conservation properties need. The bench drives every input on the falling edge from one task and draws random words over the full 13-bit instruction space. Every RAM address is written before any random reads, so no element ever reads an unwritten RAM bit. The mode is flipped only at fixed points in the random run.

// File: rtl/simd_pkg.sv
package simd_pkg;

    localparam int INSTR_W = 13;

    typedef enum logic [2:0] {
        WR_SUM, WR_CARRY, WR_BORROW, WR_NS, WR_EW, WR_C, WR_CM, WR_ZERO
    } wr_sel_e;

    typedef enum logic [2:0] {
        NS_HOLD, NS_RAM, NS_FROM_N, NS_FROM_S, NS_SUM, NS_CARRY, NS_BORROW, NS_EW
    } ns_sel_e;

    typedef enum logic [2:0] {
        EW_HOLD, EW_RAM, EW_FROM_E, EW_FROM_W, EW_SUM, EW_CARRY, EW_BORROW, EW_NS
    } ew_sel_e;

    typedef enum logic [1:0] {
        C_HOLD, C_RAM, C_CARRY, C_BORROW
    } c_sel_e;

    typedef enum logic [1:0] {
        CM_HOLD, CM_SHIFT, CM_RAM, CM_SUM
    } cm_sel_e;

    // Field order is the bit layout of the broadcast word, MSB first.
    typedef struct packed {
        wr_sel_e wr;
        ns_sel_e ns;
        ew_sel_e ew;
        c_sel_e  c;
        cm_sel_e cm;
    } instr_t;

    typedef struct packed {
        logic ns;
        logic ew;
        logic c;
        logic cm;
    } pe_regs_t;

    typedef struct packed {
        logic sm;
        logic cy;
        logic bw;
    } alu_out_t;

endpackage

// File: rtl/simd_pe_alu.sv
module simd_pe_alu
    import simd_pkg::*;
(
    input  logic     a_i,
    input  logic     b_i,
    input  logic     cin_i,
    output alu_out_t res_o
);
    logic half;

    always_comb begin
        half      = a_i ^ b_i;
        res_o.sm  = half ^ cin_i;
        res_o.cy  = (a_i & b_i) | (cin_i & half);
        res_o.bw  = (~a_i & b_i) | (cin_i & ~half);
    end
endmodule

// File: rtl/simd_link_net.sv
module simd_link_net #(
    parameter  int ROWS = 4,
    parameter  int COLS = 4,
    localparam int NPE  = ROWS * COLS
) (
    input  logic           torus_i,
    input  logic [NPE-1:0] ns_plane_i,
    input  logic [NPE-1:0] ew_plane_i,
    output logic [NPE-1:0] from_n_o,
    output logic [NPE-1:0] from_s_o,
    output logic [NPE-1:0] from_e_o,
    output logic [NPE-1:0] from_w_o
);
    for (genvar r = 0; r < ROWS; r++) begin : g_row
        for (genvar c = 0; c < COLS; c++) begin : g_col
            localparam int I = r * COLS + c;

            if (r > 0) begin : g_n_in
                assign from_n_o[I] = ns_plane_i[I-COLS];
            end else begin : g_n_edge
                assign from_n_o[I] = torus_i & ns_plane_i[(ROWS-1)*COLS + c];
            end

            if (r < ROWS - 1) begin : g_s_in
                assign from_s_o[I] = ns_plane_i[I+COLS];
            end else begin : g_s_edge
                assign from_s_o[I] = torus_i & ns_plane_i[c];
            end

            if (c < COLS - 1) begin : g_e_in
                assign from_e_o[I] = ew_plane_i[I+1];
            end else if (I < NPE - 1) begin : g_e_turn
                assign from_e_o[I] = torus_i ? ew_plane_i[r*COLS] : ew_plane_i[I+1];
            end else begin : g_e_end
                assign from_e_o[I] = torus_i & ew_plane_i[r*COLS];
            end

            if (c > 0) begin : g_w_in
                assign from_w_o[I] = ew_plane_i[I-1];
            end else if (I > 0) begin : g_w_turn
                assign from_w_o[I] = torus_i ? ew_plane_i[I+COLS-1] : ew_plane_i[I-1];
            end else begin : g_w_end
                assign from_w_o[I] = torus_i & ew_plane_i[COLS-1];
            end
        end
    end
endmodule

// File: rtl/simd_pe.sv
module simd_pe
    import simd_pkg::*;
#(
    parameter  int RAM_DEPTH = 32,
    localparam int AW        = $clog2(RAM_DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  instr_t        op_i,
    input  logic [AW-1:0] ram_addr_i,
    input  logic          ram_we_i,
    input  logic          from_n_i,
    input  logic          from_s_i,
    input  logic          from_e_i,
    input  logic          from_w_i,
    input  logic          cm_in_i,
    output pe_regs_t      regs_o
);
    pe_regs_t regs_d, regs_q;
    logic     mem_q [RAM_DEPTH];
    logic     rd_bit;
    logic     wr_bit;
    alu_out_t alu;

    assign rd_bit = mem_q[ram_addr_i];
    assign regs_o = regs_q;

    simd_pe_alu u_alu (
        .a_i   (regs_q.ns),
        .b_i   (regs_q.ew),
        .cin_i (regs_q.c),
        .res_o (alu)
    );

    always_comb begin
        regs_d = regs_q;

        unique case (op_i.ns)
            NS_HOLD:   regs_d.ns = regs_q.ns;
            NS_RAM:    regs_d.ns = rd_bit;
            NS_FROM_N: regs_d.ns = from_n_i;
            NS_FROM_S: regs_d.ns = from_s_i;
            NS_SUM:    regs_d.ns = alu.sm;
            NS_CARRY:  regs_d.ns = alu.cy;
            NS_BORROW: regs_d.ns = alu.bw;
            NS_EW:     regs_d.ns = regs_q.ew;
        endcase

        unique case (op_i.ew)
            EW_HOLD:   regs_d.ew = regs_q.ew;
            EW_RAM:    regs_d.ew = rd_bit;
            EW_FROM_E: regs_d.ew = from_e_i;
            EW_FROM_W: regs_d.ew = from_w_i;
            EW_SUM:    regs_d.ew = alu.sm;
            EW_CARRY:  regs_d.ew = alu.cy;
            EW_BORROW: regs_d.ew = alu.bw;
            EW_NS:     regs_d.ew = regs_q.ns;
        endcase

        unique case (op_i.c)
            C_HOLD:   regs_d.c = regs_q.c;
            C_RAM:    regs_d.c = rd_bit;
            C_CARRY:  regs_d.c = alu.cy;
            C_BORROW: regs_d.c = alu.bw;
        endcase

        unique case (op_i.cm)
            CM_HOLD:  regs_d.cm = regs_q.cm;
            CM_SHIFT: regs_d.cm = cm_in_i;
            CM_RAM:   regs_d.cm = rd_bit;
            CM_SUM:   regs_d.cm = alu.sm;
        endcase

        unique case (op_i.wr)
            WR_SUM:    wr_bit = alu.sm;
            WR_CARRY:  wr_bit = alu.cy;
            WR_BORROW: wr_bit = alu.bw;
            WR_NS:     wr_bit = regs_q.ns;
            WR_EW:     wr_bit = regs_q.ew;
            WR_C:      wr_bit = regs_q.c;
            WR_CM:     wr_bit = regs_q.cm;
            WR_ZERO:   wr_bit = 1'b0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            regs_q <= '0;
        end else begin
            regs_q <= regs_d;
        end
    end

    always_ff @(posedge clk) begin
        if (rst_n && ram_we_i) begin
            mem_q[ram_addr_i] <= wr_bit;
        end
    end
endmodule

// File: rtl/simd_pe_array.sv
module simd_pe_array
    import simd_pkg::*;
#(
    parameter  int ROWS      = 4,
    parameter  int COLS      = 4,
    parameter  int RAM_DEPTH = 32,
    localparam int AW        = $clog2(RAM_DEPTH),
    localparam int NPE       = ROWS * COLS
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [INSTR_W-1:0] instr,
    input  logic [AW-1:0]      ram_addr,
    input  logic               ram_we,
    input  logic               torus_mode,
    input  logic [COLS-1:0]    south_in,
    output logic [COLS-1:0]    north_out
);
    instr_t         op;
    logic [NPE-1:0] ns_plane, ew_plane, c_plane, cm_plane;
    logic [NPE-1:0] nb_n, nb_s, nb_e, nb_w, cm_feed;

    assign op        = instr_t'(instr);
    assign north_out = cm_plane[COLS-1:0];

    simd_link_net #(.ROWS(ROWS), .COLS(COLS)) u_links (
        .torus_i    (torus_mode),
        .ns_plane_i (ns_plane),
        .ew_plane_i (ew_plane),
        .from_n_o   (nb_n),
        .from_s_o   (nb_s),
        .from_e_o   (nb_e),
        .from_w_o   (nb_w)
    );

    for (genvar r = 0; r < ROWS; r++) begin : g_row
        for (genvar c = 0; c < COLS; c++) begin : g_col
            localparam int I = r * COLS + c;
            pe_regs_t q;

            if (r < ROWS - 1) begin : g_cm_mid
                assign cm_feed[I] = cm_plane[I+COLS];
            end else begin : g_cm_south
                assign cm_feed[I] = south_in[c];
            end

            simd_pe #(.RAM_DEPTH(RAM_DEPTH)) u_pe (
                .clk        (clk),
                .rst_n      (rst_n),
                .op_i       (op),
                .ram_addr_i (ram_addr),
                .ram_we_i   (ram_we),
                .from_n_i   (nb_n[I]),
                .from_s_i   (nb_s[I]),
                .from_e_i   (nb_e[I]),
                .from_w_i   (nb_w[I]),
                .cm_in_i    (cm_feed[I]),
                .regs_o     (q)
            );

            assign ns_plane[I] = q.ns;
            assign ew_plane[I] = q.ew;
            assign c_plane[I]  = q.c;
            assign cm_plane[I] = q.cm;
        end
    end
endmodule

// File: rtl/simd_pe_array_chk.sv
module simd_pe_array_chk
    import simd_pkg::*;
#(
    parameter  int ROWS = 4,
    parameter  int COLS = 4,
    localparam int NPE  = ROWS * COLS
) (
    input logic               clk,
    input logic               rst_n,
    input logic [INSTR_W-1:0] instr,
    input logic               torus_mode,
    input logic [COLS-1:0]    south_in,
    input logic [COLS-1:0]    north_out,
    input logic [NPE-1:0]     ns_plane,
    input logic [NPE-1:0]     ew_plane,
    input logic [NPE-1:0]     c_plane,
    input logic [NPE-1:0]     cm_plane
);
    instr_t f;
    assign f = instr_t'(instr);

    AST_RESET_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (ns_plane == '0 && ew_plane == '0 && c_plane == '0 && north_out == '0)); // R1

    AST_NS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        f.ns == NS_HOLD |=> $stable(ns_plane)); // R2

    AST_CM_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        f.cm == CM_HOLD |=> $stable(north_out)); // R2

    AST_CARRY_INTO_C: assert property (@(posedge clk) disable iff (!rst_n)
        f.c == C_CARRY |=> c_plane == $past((ns_plane & ew_plane) | (ns_plane & c_plane) | (ew_plane & c_plane))); // R3

    AST_TORUS_NS_KEEPS_ONES: assert property (@(posedge clk) disable iff (!rst_n)
        (torus_mode && f.ns == NS_FROM_N) |=> $countones(ns_plane) == $past($countones(ns_plane))); // R4

    AST_TORUS_EW_KEEPS_ONES: assert property (@(posedge clk) disable iff (!rst_n)
        (torus_mode && f.ew == EW_FROM_E) |=> $countones(ew_plane) == $past($countones(ew_plane))); // R5

    AST_CHAIN_EW_TAIL_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (!torus_mode && f.ew == EW_FROM_E) |=> !ew_plane[NPE-1]); // R5

    AST_SHIFT_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
        f.cm == CM_SHIFT |=> cm_plane[NPE-1 -: COLS] == $past(south_in)); // R6

    AST_SHIFT_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
        f.cm == CM_SHIFT |=> north_out == $past(cm_plane[2*COLS-1:COLS])); // R6
endmodule

bind simd_pe_array simd_pe_array_chk #(.ROWS(ROWS), .COLS(COLS)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .instr      (instr),
    .torus_mode (torus_mode),
    .south_in   (south_in),
    .north_out  (north_out),
    .ns_plane   (ns_plane),
    .ew_plane   (ew_plane),
    .c_plane    (c_plane),
    .cm_plane   (cm_plane)
);

// File: tb/tb_simd_pe_array.sv
module tb_simd_pe_array;
    import simd_pkg::*;

    localparam int ROWS  = 4;
    localparam int COLS  = 4;
    localparam int DEPTH = 32;
    localparam int AW    = 5;
    localparam int N     = ROWS * COLS;

    logic              clk = 1'b0;
    logic              rst_n;
    logic [12:0]       instr;
    logic [AW-1:0]     ram_addr;
    logic              ram_we;
    logic              torus_mode;
    logic [COLS-1:0]   south_in;
    logic [COLS-1:0]   north_out;

    always #10 clk = ~clk;

    simd_pe_array #(.ROWS(ROWS), .COLS(COLS), .RAM_DEPTH(DEPTH)) dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .instr      (instr),
        .ram_addr   (ram_addr),
        .ram_we     (ram_we),
        .torus_mode (torus_mode),
        .south_in   (south_in),
        .north_out  (north_out)
    );

    int        n_vec = 0;
    int        n_bad = 0;
    string     tag   = "R1";
    bit [N-1:0] m_ns, m_ew, m_c, m_cm;
    bit [N-1:0] m_ram [DEPTH];
    bit         m_torus = 1'b1;

    task automatic check(string t, longint act, longint exp);
        n_vec++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", t, act, exp);
        end
    endtask

    function automatic bit [12:0] mk(wr_sel_e w, ns_sel_e n, ew_sel_e e, c_sel_e c, cm_sel_e m);
        return {w, n, e, c, m};
    endfunction

    // Neighbour reads per R4 / R5
    function automatic bit [N-1:0] pull_n(bit [N-1:0] p, bit tor);
        bit [N-1:0] o;
        for (int i = 0; i < N; i++) begin
            if (i >= COLS) o[i] = p[i-COLS];
            else           o[i] = tor ? p[(ROWS-1)*COLS + i] : 1'b0;
        end
        return o;
    endfunction

    function automatic bit [N-1:0] pull_s(bit [N-1:0] p, bit tor);
        bit [N-1:0] o;
        for (int i = 0; i < N; i++) begin
            if (i < N - COLS) o[i] = p[i+COLS];
            else              o[i] = tor ? p[i - (ROWS-1)*COLS] : 1'b0;
        end
        return o;
    endfunction

    function automatic bit [N-1:0] pull_e(bit [N-1:0] p, bit tor);
        bit [N-1:0] o;
        for (int i = 0; i < N; i++) begin
            if (i % COLS != COLS - 1) o[i] = p[i+1];
            else if (tor)             o[i] = p[i-(COLS-1)];
            else if (i < N - 1)       o[i] = p[i+1];
            else                      o[i] = 1'b0;
        end
        return o;
    endfunction

    function automatic bit [N-1:0] pull_w(bit [N-1:0] p, bit tor);
        bit [N-1:0] o;
        for (int i = 0; i < N; i++) begin
            if (i % COLS != 0) o[i] = p[i-1];
            else if (tor)      o[i] = p[i+COLS-1];
            else if (i > 0)    o[i] = p[i-1];
            else               o[i] = 1'b0;
        end
        return o;
    endfunction

    // One instruction: drive on the falling edge, update the model, compare after the next rising edge.
    task automatic step(bit [12:0] ins, bit we, bit [AW-1:0] a, bit [COLS-1:0] south);
        bit [N-1:0] sm, cy, bw, rd, nns, nnew, nc, ncm, wr;
        sm = m_ns ^ m_ew ^ m_c;
        cy = (m_ns & m_ew) | (m_ns & m_c) | (m_ew & m_c);
        bw = (~m_ns & m_ew) | (~m_ns & m_c) | (m_ew & m_c);
        rd = m_ram[a];
        case (ins[9:7])
            3'd0: nns = m_ns;   3'd1: nns = rd;
            3'd2: nns = pull_n(m_ns, m_torus);
            3'd3: nns = pull_s(m_ns, m_torus);
            3'd4: nns = sm;     3'd5: nns = cy;
            3'd6: nns = bw;     default: nns = m_ew;
        endcase
        case (ins[6:4])
            3'd0: nnew = m_ew;  3'd1: nnew = rd;
            3'd2: nnew = pull_e(m_ew, m_torus);
            3'd3: nnew = pull_w(m_ew, m_torus);
            3'd4: nnew = sm;    3'd5: nnew = cy;
            3'd6: nnew = bw;    default: nnew = m_ns;
        endcase
        case (ins[3:2])
            2'd0: nc = m_c;  2'd1: nc = rd;
            2'd2: nc = cy;   default: nc = bw;
        endcase
        case (ins[1:0])
            2'd0: ncm = m_cm;
            2'd1: ncm = {south, m_cm[N-1:COLS]};
            2'd2: ncm = rd;
            default: ncm = sm;
        endcase
        case (ins[12:10])
            3'd0: wr = sm;   3'd1: wr = cy;   3'd2: wr = bw;   3'd3: wr = m_ns;
            3'd4: wr = m_ew; 3'd5: wr = m_c;  3'd6: wr = m_cm; default: wr = '0;
        endcase
        instr      = ins;
        ram_we     = we;
        ram_addr   = a;
        south_in   = south;
        torus_mode = m_torus;
        @(negedge clk);
        m_ns = nns; m_ew = nnew; m_c = nc; m_cm = ncm;
        if (we) m_ram[a] = wr;
        check(tag, north_out, m_cm[COLS-1:0]);
    endtask

    task automatic load_plane(bit [N-1:0] p, bit [AW-1:0] a);
        for (int k = 0; k < ROWS; k++)
            step(mk(WR_ZERO, NS_HOLD, EW_HOLD, C_HOLD, CM_SHIFT), 1'b0, a, p[k*COLS +: COLS]);
        step(mk(WR_CM, NS_HOLD, EW_HOLD, C_HOLD, CM_HOLD), 1'b1, a, '0);
    endtask

    task automatic read_plane(bit [AW-1:0] a, output bit [N-1:0] v);
        step(mk(WR_ZERO, NS_HOLD, EW_HOLD, C_HOLD, CM_RAM), 1'b0, a, '0);
        v[COLS-1:0] = north_out;
        for (int k = 1; k < ROWS; k++) begin
            step(mk(WR_ZERO, NS_HOLD, EW_HOLD, C_HOLD, CM_SHIFT), 1'b0, a, '0);
            v[k*COLS +: COLS] = north_out;
        end
    endtask

    // Brings NS, EW and C out through RAM scratch addresses and the shift chain.
    task automatic dump_regs();
        bit [N-1:0] v;
        step(mk(WR_NS, NS_HOLD, EW_HOLD, C_HOLD, CM_HOLD), 1'b1, 5'd28, '0);
        step(mk(WR_EW, NS_HOLD, EW_HOLD, C_HOLD, CM_HOLD), 1'b1, 5'd29, '0);
        step(mk(WR_C,  NS_HOLD, EW_HOLD, C_HOLD, CM_HOLD), 1'b1, 5'd30, '0);
        read_plane(5'd28, v);
        read_plane(5'd29, v);
        read_plane(5'd30, v);
    endtask

    task automatic arith(bit sub);
        bit [7:0]   a_v [N];
        bit [7:0]   b_v [N];
        bit [N-1:0] pa, pb, res [9];
        for (int i = 0; i < N; i++) begin
            a_v[i] = 8'($urandom);
            b_v[i] = 8'($urandom);
        end
        a_v[0] = 8'hFF; b_v[0] = 8'hFF;
        a_v[1] = 8'h00; b_v[1] = 8'h00;
        a_v[2] = 8'hFF; b_v[2] = 8'h01;
        a_v[3] = 8'h00; b_v[3] = 8'hFF;
        for (int k = 0; k < 8; k++) begin
            for (int i = 0; i < N; i++) begin
                pa[i] = a_v[i][k];
                pb[i] = b_v[i][k];
            end
            load_plane(pa, 5'(k));
            load_plane(pb, 5'(8 + k));
        end
        load_plane('0, 5'd25);
        step(mk(WR_ZERO, NS_HOLD, EW_HOLD, C_RAM, CM_HOLD), 1'b0, 5'd25, '0);
        for (int k = 0; k < 8; k++) begin
            step(mk(WR_ZERO, NS_RAM, EW_HOLD, C_HOLD, CM_HOLD), 1'b0, 5'(k), '0);
            step(mk(WR_ZERO, NS_HOLD, EW_RAM, C_HOLD, CM_HOLD), 1'b0, 5'(8 + k), '0);
            step(mk(WR_SUM, NS_HOLD, EW_HOLD, sub ? C_BORROW : C_CARRY, CM_HOLD), 1'b1, 5'(16 + k), '0);
        end
        step(mk(WR_C, NS_HOLD, EW_HOLD, C_HOLD, CM_HOLD), 1'b1, 5'd24, '0);
        for (int k = 0; k < 9; k++) read_plane(5'(16 + k), res[k]);
        for (int i = 0; i < N; i++) begin
            bit [8:0] got, exp;
            for (int k = 0; k < 9; k++) got[k] = res[k][i];
            exp = sub ? 9'({1'b0, a_v[i]} - {1'b0, b_v[i]}) : 9'({1'b0, a_v[i]} + {1'b0, b_v[i]});
            check(sub ? "R8 subtract" : "R8 add", got, exp);
        end
    endtask

    initial begin
        #(20 * 200000);
        n_bad++;
        $display("FAIL R2: watchdog expired, actual hang expected finish");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        rst_n = 1'b0; instr = '0; ram_addr = '0; ram_we = 1'b0;
        torus_mode = 1'b1; south_in = '0;
        m_ns = '0; m_ew = '0; m_c = '0; m_cm = '0;
        for (int a = 0; a < DEPTH; a++) m_ram[a] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: registers clear, top row of the shift chain reads zero
        check("R1 reset north_out", north_out, 0);
        tag = "R1";
        for (int k = 0; k < ROWS; k++)
            step(mk(WR_ZERO, NS_HOLD, EW_HOLD, C_HOLD, CM_SHIFT), 1'b0, '0, '0);
        dump_regs();

        // R2 / R6: fill every RAM address through the shift chain
        tag = "R6 load";
        for (int a = 0; a < DEPTH; a++) load_plane(N'($urandom), 5'(a));

        // R9: same-cycle write and read at one address
        tag = "R9";
        step(mk(WR_ZERO, NS_RAM, EW_HOLD, C_HOLD, CM_HOLD), 1'b0, 5'd3, '0);
        step(mk(WR_ZERO, NS_RAM, EW_HOLD, C_HOLD, CM_RAM), 1'b1, 5'd3, '0);
        step(mk(WR_ZERO, NS_RAM, EW_HOLD, C_HOLD, CM_RAM), 1'b0, 5'd3, '0);
        dump_regs();

        // R4 / R5: neighbour moves in both modes, with single marked corners
        for (int mode = 0; mode < 2; mode++) begin
            m_torus = mode[0];
            tag = "R4";
            load_plane(16'h8001, 5'd27);
            step(mk(WR_ZERO, NS_RAM, EW_RAM, C_HOLD, CM_HOLD), 1'b0, 5'd27, '0);
            step(mk(WR_ZERO, NS_FROM_N, EW_HOLD, C_HOLD, CM_HOLD), 1'b0, '0, '0);
            dump_regs();
            step(mk(WR_ZERO, NS_FROM_S, EW_HOLD, C_HOLD, CM_HOLD), 1'b0, '0, '0);
            step(mk(WR_ZERO, NS_FROM_S, EW_HOLD, C_HOLD, CM_HOLD), 1'b0, '0, '0);
            dump_regs();
            tag = "R5";
            step(mk(WR_ZERO, NS_HOLD, EW_FROM_E, C_HOLD, CM_HOLD), 1'b0, '0, '0);
            dump_regs();
            step(mk(WR_ZERO, NS_HOLD, EW_FROM_W, C_HOLD, CM_HOLD), 1'b0, '0, '0);
            step(mk(WR_ZERO, NS_HOLD, EW_FROM_W, C_HOLD, CM_HOLD), 1'b0, '0, '0);
            dump_regs();
            step(mk(WR_ZERO, NS_EW, EW_NS, C_HOLD, CM_HOLD), 1'b0, '0, '0);
            dump_regs();
        end
        m_torus = 1'b1;

        // R3 / R7: ALU outputs into every destination
        tag = "R3";
        for (int t = 0; t < 24; t++) begin
            step(mk(WR_ZERO, NS_RAM, EW_HOLD, C_HOLD, CM_HOLD), 1'b0, 5'($urandom_range(0, 23)), '0);
            step(mk(WR_ZERO, NS_HOLD, EW_RAM, C_HOLD, CM_HOLD), 1'b0, 5'($urandom_range(0, 23)), '0);
            step(mk(WR_ZERO, NS_HOLD, EW_HOLD, C_RAM, CM_HOLD), 1'b0, 5'($urandom_range(0, 23)), '0);
            tag = "R7";
            step(mk(wr_sel_e'(t % 3), NS_HOLD, EW_HOLD, c_sel_e'(2 + t % 2), CM_SUM), 1'b1, 5'd28, '0);
            tag = "R3";
            step(mk(WR_ZERO, ns_sel_e'(4 + t % 3), ew_sel_e'(4 + (t + 1) % 3), C_HOLD, CM_HOLD), 1'b0, '0, '0);
            dump_regs();
        end

        // R6: shift runs while the ALU works
        tag = "R6";
        for (int t = 0; t < 40; t++)
            step(mk(WR_ZERO, ns_sel_e'($urandom_range(0, 7)), ew_sel_e'($urandom_range(0, 7)),
                    c_sel_e'($urandom_range(0, 3)), CM_SHIFT), 1'b0, 5'($urandom_range(0, 31)),
                 COLS'($urandom));

        // R8: bit-serial arithmetic against integer results
        arith(1'b0);
        arith(1'b1);

        // R2: constrained random instruction stream
        tag = "R2";
        for (int t = 0; t < 3000; t++) begin
            if (t % 200 == 0) m_torus = ~m_torus;
            step(13'($urandom), 1'($urandom), 5'($urandom), COLS'($urandom));
            if (t % 500 == 499) dump_regs();
        end
        dump_regs();

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule